// File: doc/BRIEF.md
# Boot Strap Capture and Reset-Halt Controller

This block records the device's boot-configuration strap pins once per fundamental reset and keeps that snapshot for the rest of the device to use. The external active-low global reset is synchronized to the clock. The straps are captured on the edge where the synchronized reset goes inactive, and from then on they are shown unchanged in a read-only status word. The block also drives the effective configuration outputs. Only the 2-bit clock-mode field can be replaced by software, through an override register. Frequency select, port-merge enables, slave address bits and the 4-bit switch mode always follow the captured straps.

The block owns the core reset release. When the halt strap is low, the core leaves reset a fixed number of cycles after capture. When the halt strap is high, the core stays in reset while the register port keeps working, so a management agent can inspect and adjust settings. The agent then lets the core run by writing 0 to the halt bit. A power-up reset and a reset asserted with power applied take exactly the same path.

Register map (address `regAddr`): 0 = strap status (read-only), 1 = control, halt in bit 0, 2 = clock-mode override in bits [1:0]. Reads of address 3 return zero.

Top module: `boot_strap_ctl`

## Requirements
- R1: At the second rising clock edge after `rstGlobalN` goes high, the straps are captured into `statusVec` with the layout [0] frequency select, [2:1] clock mode, [8:3] merge enables, [9] halt strap, [11:10] slave address, [15:12] switch mode. Address 0 reads back the same word.
- R2: After capture, `statusVec` does not change while `rstGlobalN` stays high, even if the strap pins change.
- R3: Every assertion of `rstGlobalN` clears the override and the halt state and repeats the full capture sequence. A reset that follows a running period gives the same result as the first reset after power-up.
- R4: While `rstGlobalN` is low, `statusVec` and `coreRstN` are 0 without waiting for a clock edge. `coreRstN` stays 0 until capture has happened.
- R5: With the halt strap low, `coreRstN` rises after the 4th rising edge that follows the capture edge.
- R6: With the halt strap high, `coreRstN` stays 0 after capture, and register reads and override writes keep working.
- R7: While halted, a write of 0 to bit 0 of address 1 raises `coreRstN` after that edge. A write of 1 keeps the core in reset.
- R8: A write to address 2 after capture sets `effClkMode` to the written bits [1:0] from the next cycle on. `statusVec[2:1]` keeps the captured strap value. Address 2 reads the effective clock mode.
- R9: `effFreqSel`, `effMerge`, `effSlvAddr` and `effSwMode` always equal the captured fields. Register writes never change them.
- R10: Writes to address 0 are ignored. After the core has been released, a write of 1 to the halt bit is ignored, and `coreRstN` stays 1 until the next global reset.
- R11: The halt bit, read at address 1 bit 0, is seeded from the halt strap at capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstGlobalN | input | 1 | Active-low global (fundamental) reset, asynchronous |
| strapFreqSel | input | 1 | Clock-frequency select strap |
| strapClkMode | input | 2 | Clock-mode strap |
| strapMerge | input | MERGE_W (6) | Port-pair merge enable straps |
| strapHalt | input | 1 | Reset-halt strap |
| strapSlvAddr | input | SADDR_W (2) | Slave address straps |
| strapSwMode | input | MODE_W (4) | Switch-mode straps |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (2) | Register address |
| regWrData | input | STAT_W (16) | Register write data |
| regRdData | output | STAT_W (16) | Register read data for `regAddr`, combinational |
| statusVec | output | STAT_W (16) | Captured strap status |
| effFreqSel | output | 1 | Effective frequency select |
| effClkMode | output | 2 | Effective clock mode (strap or override) |
| effMerge | output | MERGE_W (6) | Effective merge enables |
| effSlvAddr | output | SADDR_W (2) | Effective slave address |
| effSwMode | output | MODE_W (4) | Effective switch mode |
| coreRstN | output | 1 | Core reset release, active low |

## Verification
The bench targets the exact capture edge and the exact release cycle. A design that captures one edge early or late shows the wrong `statusVec`, because the straps change around reset release, and an off-by-one release counter is seen at the precise cycle. It changes the straps after capture, writes the status address and tries to set halt again after release. A design that re-samples or accepts those writes would show a changed status or a core pushed back into reset. A warm reset is applied after a running period that used an override. This exposes an override that survives reset, an asynchronous clear that waits for a clock, and a halt that does not hold the core while the register port stays usable.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    ST_RESET,
    ST_COUNT,
    ST_HALT,
    ST_RUN
  } ctlState_t;

  typedef struct packed {
    logic capture;
    logic ovrWrite;
  } dpStrobe_t;

  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned REG_CLKOVR = 2;

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstGlobalN,
  output logic rstSyncN,
  output logic captureEdge
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstGlobalN) begin
    if (!rstGlobalN) chain <= '0;
    else             chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstSyncN    = chain[STAGES-1];
  assign captureEdge = chain[STAGES-2] & ~chain[STAGES-1];

endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned RELEASE_DLY = 4,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstGlobalN,
  input  logic              captureEdge,
  input  logic              strapHalt,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrHaltVal,
  output dpStrobe_t         strobe,
  output logic              haltBit,
  output logic              coreRstN
);

  localparam int unsigned CNT_W = $clog2(RELEASE_DLY) + 1;

  ctlState_t        state;
  logic [CNT_W-1:0] dlyCnt;
  logic             ctrlWr;

  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(REG_CTRL));

  always_comb begin
    strobe.capture  = captureEdge && (state == ST_RESET);
    strobe.ovrWrite = regWrEn && (regAddr == ADDR_W'(REG_CLKOVR)) && (state != ST_RESET);
  end

  always_ff @(posedge clk or negedge rstGlobalN) begin
    if (!rstGlobalN) begin
      state   <= ST_RESET;
      haltBit <= 1'b0;
      dlyCnt  <= '0;
    end else begin
      unique case (state)
        ST_RESET: begin
          if (captureEdge) begin
            haltBit <= strapHalt;
            dlyCnt  <= '0;
            state   <= strapHalt ? ST_HALT : ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (dlyCnt == CNT_W'(RELEASE_DLY - 1)) state <= ST_RUN;
          else                                   dlyCnt <= dlyCnt + 1'b1;
        end
        ST_HALT: begin
          if (ctrlWr) begin
            haltBit <= wrHaltVal;
            if (!wrHaltVal) state <= ST_RUN;
          end
        end
        ST_RUN: ;
        default: state <= ST_RESET;
      endcase
    end
  end

  assign coreRstN = (state == ST_RUN);

endmodule

// File: rtl/strap_dpath.sv
module strap_dpath
  import strap_pkg::*;
#(
  parameter int unsigned MERGE_W = 6,
  parameter int unsigned SADDR_W = 2,
  parameter int unsigned MODE_W  = 4,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned STAT_W  = 4 + MERGE_W + SADDR_W + MODE_W
) (
  input  logic               clk,
  input  logic               rstGlobalN,
  input  dpStrobe_t          strobe,
  input  logic               strapFreqSel,
  input  logic [1:0]         strapClkMode,
  input  logic [MERGE_W-1:0] strapMerge,
  input  logic               strapHalt,
  input  logic [SADDR_W-1:0] strapSlvAddr,
  input  logic [MODE_W-1:0]  strapSwMode,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [1:0]         wrClkMode,
  input  logic               haltBit,
  output logic [STAT_W-1:0]  statusVec,
  output logic               effFreqSel,
  output logic [1:0]         effClkMode,
  output logic [MERGE_W-1:0] effMerge,
  output logic [SADDR_W-1:0] effSlvAddr,
  output logic [MODE_W-1:0]  effSwMode,
  output logic [STAT_W-1:0]  regRdData
);

  localparam int unsigned CLK_LSB   = 1;
  localparam int unsigned MERGE_LSB = 3;
  localparam int unsigned SADDR_LSB = MERGE_LSB + MERGE_W + 1;
  localparam int unsigned MODE_LSB  = SADDR_LSB + SADDR_W;

  logic [STAT_W-1:0] capReg;
  logic              ovrValid;
  logic [1:0]        ovrMode;

  always_ff @(posedge clk or negedge rstGlobalN) begin
    if (!rstGlobalN) begin
      capReg <= '0;
    end else if (strobe.capture) begin
      capReg <= {strapSwMode, strapSlvAddr, strapHalt, strapMerge, strapClkMode, strapFreqSel};
    end
  end

  always_ff @(posedge clk or negedge rstGlobalN) begin
    if (!rstGlobalN) begin
      ovrValid <= 1'b0;
      ovrMode  <= '0;
    end else if (strobe.ovrWrite) begin
      ovrValid <= 1'b1;
      ovrMode  <= wrClkMode;
    end
  end

  assign statusVec  = capReg;
  assign effFreqSel = capReg[0];
  assign effClkMode = ovrValid ? ovrMode : capReg[CLK_LSB +: 2];
  assign effMerge   = capReg[MERGE_LSB +: MERGE_W];
  assign effSlvAddr = capReg[SADDR_LSB +: SADDR_W];
  assign effSwMode  = capReg[MODE_LSB +: MODE_W];

  always_comb begin
    unique case (regAddr)
      ADDR_W'(REG_STATUS): regRdData = capReg;
      ADDR_W'(REG_CTRL):   regRdData = STAT_W'(haltBit);
      ADDR_W'(REG_CLKOVR): regRdData = STAT_W'(effClkMode);
      default:             regRdData = '0;
    endcase
  end

endmodule

// File: rtl/boot_strap_ctl.sv
module boot_strap_ctl
  import strap_pkg::*;
#(
  parameter int unsigned MERGE_W     = 6,
  parameter int unsigned SADDR_W     = 2,
  parameter int unsigned MODE_W      = 4,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned RELEASE_DLY = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned STAT_W     = 4 + MERGE_W + SADDR_W + MODE_W
) (
  input  logic               clk,
  input  logic               rstGlobalN,
  input  logic               strapFreqSel,
  input  logic [1:0]         strapClkMode,
  input  logic [MERGE_W-1:0] strapMerge,
  input  logic               strapHalt,
  input  logic [SADDR_W-1:0] strapSlvAddr,
  input  logic [MODE_W-1:0]  strapSwMode,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [STAT_W-1:0]  regWrData,
  output logic [STAT_W-1:0]  regRdData,
  output logic [STAT_W-1:0]  statusVec,
  output logic               effFreqSel,
  output logic [1:0]         effClkMode,
  output logic [MERGE_W-1:0] effMerge,
  output logic [SADDR_W-1:0] effSlvAddr,
  output logic [MODE_W-1:0]  effSwMode,
  output logic               coreRstN
);

  logic      rstSyncN;
  logic      captureEdge;
  logic      haltBit;
  dpStrobe_t strobe;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk         (clk),
    .rstGlobalN  (rstGlobalN),
    .rstSyncN    (rstSyncN),
    .captureEdge (captureEdge)
  );

  strap_ctrl #(.RELEASE_DLY(RELEASE_DLY), .ADDR_W(ADDR_W)) uCtrl (
    .clk         (clk),
    .rstGlobalN  (rstGlobalN),
    .captureEdge (captureEdge && !rstSyncN),
    .strapHalt   (strapHalt),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .wrHaltVal   (regWrData[0]),
    .strobe      (strobe),
    .haltBit     (haltBit),
    .coreRstN    (coreRstN)
  );

  strap_dpath #(
    .MERGE_W (MERGE_W), .SADDR_W (SADDR_W), .MODE_W (MODE_W),
    .ADDR_W  (ADDR_W),  .STAT_W  (STAT_W)
  ) uDpath (
    .clk          (clk),
    .rstGlobalN   (rstGlobalN),
    .strobe       (strobe),
    .strapFreqSel (strapFreqSel),
    .strapClkMode (strapClkMode),
    .strapMerge   (strapMerge),
    .strapHalt    (strapHalt),
    .strapSlvAddr (strapSlvAddr),
    .strapSwMode  (strapSwMode),
    .regAddr      (regAddr),
    .wrClkMode    (regWrData[1:0]),
    .haltBit      (haltBit),
    .statusVec    (statusVec),
    .effFreqSel   (effFreqSel),
    .effClkMode   (effClkMode),
    .effMerge     (effMerge),
    .effSlvAddr   (effSlvAddr),
    .effSwMode    (effSwMode),
    .regRdData    (regRdData)
  );

endmodule

// File: rtl/boot_strap_ctl_chk.sv
module boot_strap_ctl_chk #(
  parameter int unsigned STAT_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rstGlobalN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [STAT_W-1:0] regWrData,
  input logic [STAT_W-1:0] statusVec,
  input logic [1:0]        effClkMode,
  input logic              coreRstN
);

  logic [1:0] edgesUp;

  always_ff @(posedge clk or negedge rstGlobalN) begin
    if (!rstGlobalN)            edgesUp <= 2'd0;
    else if (edgesUp != 2'd3)   edgesUp <= edgesUp + 2'd1;
  end

  // R4
  core_held_chk: assert property (@(posedge clk) disable iff (!rstGlobalN)
    (edgesUp != 2'd3) |-> !coreRstN);

  // R2
  status_stable_chk: assert property (@(posedge clk) disable iff (!rstGlobalN)
    (edgesUp >= 2'd2) |=> $stable(statusVec));

  // R8
  ovr_apply_chk: assert property (@(posedge clk) disable iff (!rstGlobalN)
    (edgesUp >= 2'd2 && regWrEn && regAddr == ADDR_W'(2)) |=> (effClkMode == $past(regWrData[1:0])));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstGlobalN)
    (edgesUp >= 2'd2 && !(regWrEn && regAddr == ADDR_W'(2))) |=> $stable(effClkMode));

  // R10
  release_sticky_chk: assert property (@(posedge clk) disable iff (!rstGlobalN)
    coreRstN |=> coreRstN);

endmodule

bind boot_strap_ctl boot_strap_ctl_chk #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstGlobalN (rstGlobalN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .statusVec  (statusVec),
  .effClkMode (effClkMode),
  .coreRstN   (coreRstN)
);

// File: tb/tb_boot_strap_ctl.sv
module tb_boot_strap_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstGlobalN = 1'b1;
  logic        strapFreqSel = 1'b0;
  logic [1:0]  strapClkMode = '0;
  logic [5:0]  strapMerge = '0;
  logic        strapHalt = 1'b0;
  logic [1:0]  strapSlvAddr = '0;
  logic [3:0]  strapSwMode = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData, statusVec;
  logic        effFreqSel, coreRstN;
  logic [1:0]  effClkMode, effSlvAddr;
  logic [5:0]  effMerge;
  logic [3:0]  effSwMode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  boot_strap_ctl dut (
    .clk(clk), .rstGlobalN(rstGlobalN),
    .strapFreqSel(strapFreqSel), .strapClkMode(strapClkMode), .strapMerge(strapMerge),
    .strapHalt(strapHalt), .strapSlvAddr(strapSlvAddr), .strapSwMode(strapSwMode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .statusVec(statusVec), .effFreqSel(effFreqSel), .effClkMode(effClkMode),
    .effMerge(effMerge), .effSlvAddr(effSlvAddr), .effSwMode(effSwMode), .coreRstN(coreRstN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int          mSync = 0;     // clock edges seen with reset high (saturates at 2)
  int          mState = 0;    // 0 reset, 1 counting, 2 halted, 3 running
  int          mTicks = 0;
  bit          mHalt = 0;
  bit          mOvrValid = 0;
  logic [1:0]  mOvr = '0;
  logic [15:0] mStatus = '0;

  always @(posedge clk) begin
    if (!rstGlobalN) begin
      mSync = 0; mState = 0; mTicks = 0; mHalt = 0; mOvrValid = 0; mOvr = '0; mStatus = '0;
    end else begin
      bit wr;
      wr = regWrEn && (mState != 0);
      if (wr && regAddr == 2'd2) begin mOvrValid = 1; mOvr = regWrData[1:0]; end
      case (mState)
        0: if (mSync == 1) begin
             mStatus = {strapSwMode, strapSlvAddr, strapHalt, strapMerge, strapClkMode, strapFreqSel};
             mHalt = strapHalt;
             mTicks = 0;
             mState = strapHalt ? 2 : 1;
           end
        1: begin mTicks++; if (mTicks == 4) mState = 3; end
        2: if (wr && regAddr == 2'd1) begin
             mHalt = regWrData[0];
             if (!regWrData[0]) mState = 3;
           end
        default: ;
      endcase
      if (mSync < 2) mSync++;
    end
  end

  function automatic logic [1:0] mEffMode();
    return mOvrValid ? mOvr : mStatus[2:1];
  endfunction

  function automatic logic [15:0] mRead(logic [1:0] a);
    case (a)
      2'd0: return mStatus;
      2'd1: return {15'd0, mHalt};
      2'd2: return {14'd0, mEffMode()};
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R1",  32'(statusVec),  32'(mStatus),        "statusVec");
      check("R8",  32'(effClkMode), 32'(mEffMode()),     "effClkMode");
      check("R5",  32'(coreRstN),   32'(mState == 3),    "coreRstN");
      check("R11", 32'(regRdData),  32'(mRead(regAddr)), "regRdData");
      check("R9",  32'({effSwMode, effSlvAddr, effMerge, effFreqSel}),
                   32'({mStatus[15:12], mStatus[11:10], mStatus[8:3], mStatus[0]}), "fixed fields");
    end
  end

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected end before %0d", cyc, WATCHDOG);
      finishRun();
    end
  end

  task automatic drv();
    @(negedge clk); #1;
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    drv(); regWrEn = 1'b1; regAddr = a; regWrData = d;
    drv(); regWrEn = 1'b0;
  endtask

  task automatic setStraps(logic f, logic [1:0] cm, logic [5:0] mg, logic h, logic [1:0] sa, logic [3:0] sm);
    strapFreqSel = f; strapClkMode = cm; strapMerge = mg; strapHalt = h; strapSlvAddr = sa; strapSwMode = sm;
  endtask

  logic [15:0] firstStatus;

  initial begin
    #1 rstGlobalN = 1'b0;
    setStraps(1'b1, 2'b10, 6'b101010, 1'b0, 2'b01, 4'h5);
    repeat (3) drv();
    check("R4", 32'(coreRstN), 32'd0, "core in reset during global reset");
    check("R4", 32'(statusVec), 32'd0, "status cleared during global reset");

    // Release, no halt: count negedges until the core comes out of reset
    rstGlobalN = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check("R5", 32'(coreRstN), 32'd0, "core still held before release cycle");
    end
    @(negedge clk);
    check("R5", 32'(coreRstN), 32'd1, "core released 4 edges after capture");
    check("R1", 32'(statusVec), 32'h5 << 12 | 32'h1 << 10 | 32'h2A << 3 | 32'h2 << 1 | 32'h1, "captured vector");
    firstStatus = statusVec;

    // Strap changes after capture are not seen
    #1 setStraps(1'b0, 2'b01, 6'b010101, 1'b1, 2'b10, 4'hA);
    repeat (3) drv();
    check("R2", 32'(statusVec), 32'(firstStatus), "status unchanged after strap change");

    // Writes to status and re-setting halt after release are ignored
    regWrite(2'd0, 16'hFFFF);
    check("R10", 32'(statusVec), 32'(firstStatus), "status write ignored");
    regWrite(2'd1, 16'h0001);
    repeat (2) drv();
    check("R10", 32'(coreRstN), 32'd1, "halt set after release ignored");
    regAddr = 2'd1;
    drv();
    check("R10", 32'(regRdData), 32'd0, "halt bit stays clear");

    // Clock-mode override
    regWrite(2'd2, 16'h0001);
    check("R8", 32'(effClkMode), 32'd1, "override applied");
    check("R8", 32'(statusVec[2:1]), 32'd2, "status keeps strap clock mode");
    check("R9", 32'(effSwMode), 32'h5, "switch mode unaffected by writes");

    // Warm reset with halt strap: asynchronous clear first
    setStraps(1'b0, 2'b11, 6'b000111, 1'b1, 2'b10, 4'hC);
    rstGlobalN = 1'b0;
    #1;
    check("R4", 32'(coreRstN), 32'd0, "asynchronous core reset");
    check("R4", 32'(statusVec), 32'd0, "asynchronous status clear");
    repeat (2) drv();
    rstGlobalN = 1'b1;
    repeat (3) drv();
    check("R3", 32'(effClkMode), 32'd3, "override cleared by warm reset");
    regAddr = 2'd1;
    drv();
    check("R11", 32'(regRdData), 32'd1, "halt bit seeded from strap");
    repeat (20) drv();
    check("R6", 32'(coreRstN), 32'd0, "core held by halt strap");
    regWrite(2'd2, 16'h0002);
    check("R6", 32'(effClkMode), 32'd2, "override works while halted");
    regWrite(2'd1, 16'h0001);
    drv();
    check("R7", 32'(coreRstN), 32'd0, "writing 1 keeps halt");
    drv(); regWrEn = 1'b1; regAddr = 2'd1; regWrData = 16'h0000;
    @(negedge clk);
    check("R7", 32'(coreRstN), 32'd1, "halt clear releases core next cycle");
    #1 regWrEn = 1'b0;

    // Another warm reset with the first strap set: same result as the first reset
    drv();
    setStraps(1'b1, 2'b10, 6'b101010, 1'b0, 2'b01, 4'h5);
    rstGlobalN = 1'b0;
    repeat (2) drv();
    rstGlobalN = 1'b1;
    repeat (8) drv();
    check("R3", 32'(statusVec), 32'(firstStatus), "warm reset matches cold reset");
    check("R3", 32'(coreRstN), 32'd1, "warm reset releases core");
    repeat (2) drv();
    finishRun();
  end

endmodule